// File: doc/BRIEF.md
# Platform Interrupt Controller With Claim/Complete

This block gathers level-sensitive interrupt sources and routes them to processor harts. Each hart has a machine-mode context and, when the supervisor variant is built, a supervisor-mode context. Software programs each source's priority, an enable bit per source and per context, and a threshold per context. A context raises its interrupt line while some source is pending, not yet claimed, enabled for that context, and of a priority strictly above the context's threshold.

All programming goes through a small word-wide register bus with a one-cycle read response. An interrupt handler reads its context's claim register to learn which source to service. That read also moves the source from pending to claimed, so no other context sees it. When the handler is finished it writes the source's identifier back to the same register, which releases the claim.

Top module: `irq_hub`

## Requirements
- R1: Only word-aligned accesses inside a mapped region take effect. A read that is misaligned or falls outside every region returns 0; such a write changes nothing. Every request cycle is followed on the next cycle by `rsp_valid_o` high, with the read data on `rsp_rdata_o`.
- R2: The priority word at byte `PRIO_BASE + 4*k` belongs to source k+1 (k from 0 to N_SRC-2). A write keeps only data bits [2:0], and a read returns that 3-bit value zero-extended.
- R3: A source's pending bit is set when its input changes to 1 and cleared when its input changes to 0. An input that stays high after a claim does not set the bit again. Pending bit s is bit s%32 of the word at `PEND_BASE + 4*(s/32)`. Writes to this region are ignored.
- R4: Enable word w of context c is at `ENA_BASE + c*ENA_STRIDE + 4*w`, and its bit b enables source 32*w+b. Word indices of NWORDS or more are unmapped (R1 applies). Writing one context's enables leaves the other contexts' enables unchanged.
- R5: The threshold of context c is at `CTX_BASE + c*CTX_STRIDE`. A write takes effect only when the data is no greater than NUM_PRIO; otherwise the old threshold stays.
- R6: A context's line is high exactly when some source is pending, not claimed, enabled for it, and has a priority strictly greater than its threshold. The line reflects any state change right after the clock edge that makes that change.
- R7: A read of context c's claim register at `CTX_BASE + c*CTX_STRIDE + 4` returns the eligible source (as defined in R6) with the highest priority, taking the lowest identifier on a tie, or 0 if there is none. For a nonzero result, that source's pending bit is cleared and its claimed bit is set in the same cycle, and this holds for every context.
- R8: A write to any claim register whose data is below N_SRC clears that source's claimed bit. Larger values are ignored.
- R9: Context 2h drives `m_eip_o[h]` and context 2h+1 drives `s_eip_o[h]`.
- R10: After reset all priorities, pending, claimed and enable bits and all thresholds are zero, and every interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Bus request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response for the previous cycle's request |
| rsp_rdata_o | output | 32 | Read data, 0 for writes and unmapped reads |
| src_i | input | N_SRC | Level-sensitive interrupt sources; bit 0 is reserved |
| m_eip_o | output | N_HART | Machine external interrupt line per hart |
| s_eip_o | output | N_HART | Supervisor external interrupt line per hart |

## Verification
Register writes, claims and completions act at the clock edge that samples the request, and the interrupt lines follow from that edge with no further delay. Read data appears one edge after the request. A change on a source input reaches pending and the lines at the first edge that samples it. The bench drives every stimulus on a falling edge and samples each result on the next falling edge, which falls after the single register stage on each of these paths.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam int PRIO_W = 3;

   typedef logic [PRIO_W-1:0] prio_t;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_PRIO,
      RG_PEND,
      RG_ENA,
      RG_THR,
      RG_CLAIM
   } region_e;

endpackage

// File: rtl/irq_hub_pick.sv
module irq_hub_pick
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC     = 40,
   parameter int unsigned ID_W      = 6,
   parameter bit          PICK_TREE = 1'b1
) (
   input  logic [N_SRC-1:0]  cand,
   input  prio_t [N_SRC-1:0] prio,
   input  prio_t             thr,
   output logic [ID_W-1:0]   id,
   output logic              hit
);

   if (PICK_TREE) begin : g_tree
      localparam int unsigned LEAVES = 1 << $clog2(N_SRC);
      localparam int unsigned NODES  = 2 * LEAVES - 1;

      logic            nv  [NODES];
      prio_t           np  [NODES];
      logic [ID_W-1:0] nid [NODES];

      for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
         if (i > 0 && i < N_SRC) begin : g_used
            assign nv[LEAVES-1+i]  = cand[i] && (prio[i] > thr);
            assign np[LEAVES-1+i]  = prio[i];
            assign nid[LEAVES-1+i] = ID_W'(i);
         end else begin : g_void
            assign nv[LEAVES-1+i]  = 1'b0;
            assign np[LEAVES-1+i]  = '0;
            assign nid[LEAVES-1+i] = '0;
         end
      end

      // left subtree holds lower identifiers, so it wins a tie
      for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
         logic take_l;
         assign take_l = nv[2*n+1] && (!nv[2*n+2] || (np[2*n+1] >= np[2*n+2]));
         assign nv[n]  = nv[2*n+1] | nv[2*n+2];
         assign np[n]  = take_l ? np[2*n+1]  : np[2*n+2];
         assign nid[n] = take_l ? nid[2*n+1] : nid[2*n+2];
      end

      assign hit = nv[0];
      assign id  = nv[0] ? nid[0] : '0;
   end else begin : g_scan
      always_comb begin
         prio_t best;
         best = thr;
         id   = '0;
         for (int i = 1; i < int'(N_SRC); i++) begin
            if (cand[i] && (prio[i] > best)) begin
               best = prio[i];
               id   = ID_W'(i);
            end
         end
         hit = (id != '0);
      end
   end

endmodule

// File: rtl/irq_hub_srcbank.sv
module irq_hub_srcbank
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC = 40,
   parameter int unsigned ID_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic              prio_we,
   input  logic [ID_W-1:0]   prio_idx,
   input  prio_t             prio_wdata,
   input  logic              take_en,
   input  logic [ID_W-1:0]   take_id,
   input  logic              give_en,
   input  logic [ID_W-1:0]   give_id,
   output logic [N_SRC-1:0]  pending,
   output logic [N_SRC-1:0]  claimed,
   output prio_t [N_SRC-1:0] prio
);

   logic [N_SRC-1:0] src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_i;
   end

   // identifier 0 means "nothing": its state is tied off
   assign pending[0] = 1'b0;
   assign claimed[0] = 1'b0;
   assign prio[0]    = '0;

   for (genvar s = 1; s < N_SRC; s++) begin : g_src
      logic hit_take, hit_give, hit_prio;
      assign hit_take = take_en && (take_id == ID_W'(s));
      assign hit_give = give_en && (give_id == ID_W'(s));
      assign hit_prio = prio_we && (prio_idx == ID_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pending[s] <= 1'b0;
            claimed[s] <= 1'b0;
            prio[s]    <= '0;
         end else begin
            if (src_i[s] != src_q[s]) pending[s] <= src_i[s];
            else if (hit_take)        pending[s] <= 1'b0;

            if (hit_take)      claimed[s] <= 1'b1;
            else if (hit_give) claimed[s] <= 1'b0;

            if (hit_prio) prio[s] <= prio_wdata;
         end
      end
   end

endmodule

// File: rtl/irq_hub_ctx.sv
module irq_hub_ctx
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_SRC     = 40,
   parameter int unsigned NWORDS    = 2,
   parameter int unsigned ID_W      = 6,
   parameter int unsigned WSEL_W    = 1,
   parameter bit          PICK_TREE = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ena_we,
   input  logic [WSEL_W-1:0]        ena_word,
   input  logic [31:0]              wdata,
   input  logic                     thr_we,
   input  logic [N_SRC-1:0]         pending,
   input  logic [N_SRC-1:0]         claimed,
   input  prio_t [N_SRC-1:0]        prio,
   output logic [NWORDS-1:0][31:0]  ena_q,
   output prio_t                    thr_q,
   output logic [ID_W-1:0]          best_id,
   output logic                     irq
);

   localparam int unsigned VEC_W = NWORDS * 32;
   localparam logic [VEC_W-1:0] VMASK = {VEC_W{1'b1}} >> (VEC_W - N_SRC);
   localparam logic [NWORDS-1:0][31:0] WMASK = VMASK;

   logic [VEC_W-1:0] ena_flat;
   logic [N_SRC-1:0] cand;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ena_q <= '0;
         thr_q <= '0;
      end else begin
         if (ena_we) ena_q[ena_word] <= wdata & WMASK[ena_word];
         if (thr_we) thr_q <= wdata[PRIO_W-1:0];
      end
   end

   assign ena_flat = ena_q;
   assign cand     = pending & ~claimed & ena_flat[N_SRC-1:0];

   irq_hub_pick #(
      .N_SRC     (N_SRC),
      .ID_W      (ID_W),
      .PICK_TREE (PICK_TREE)
   ) u_pick (
      .cand (cand),
      .prio (prio),
      .thr  (thr_q),
      .id   (best_id),
      .hit  (irq)
   );

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_HART     = 2,
   parameter bit          HAS_SUP    = 1'b1,
   parameter int unsigned N_SRC      = 40,
   parameter int unsigned NUM_PRIO   = 7,
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned PRIO_BASE  = 32'h0000,
   parameter int unsigned PEND_BASE  = 32'h1000,
   parameter int unsigned ENA_BASE   = 32'h2000,
   parameter int unsigned ENA_STRIDE = 32'h0080,
   parameter int unsigned CTX_BASE   = 32'h4000,
   parameter int unsigned CTX_STRIDE = 32'h0100,
   parameter bit          PICK_TREE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [31:0]       req_wdata_i,
   output logic              rsp_valid_o,
   output logic [31:0]       rsp_rdata_o,
   input  logic [N_SRC-1:0]  src_i,
   output logic [N_HART-1:0] m_eip_o,
   output logic [N_HART-1:0] s_eip_o
);

   localparam int unsigned N_CTX  = HAS_SUP ? 2 * N_HART : N_HART;
   localparam int unsigned NWORDS = (N_SRC + 31) / 32;
   localparam int unsigned ID_W   = $clog2(N_SRC);
   localparam int unsigned CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1;
   localparam int unsigned WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
   localparam int unsigned ENA_SH = $clog2(ENA_STRIDE);
   localparam int unsigned CTX_SH = $clog2(CTX_STRIDE);

   localparam logic [31:0] PRIO_LO = 32'(PRIO_BASE);
   localparam logic [31:0] PRIO_HI = 32'(PRIO_BASE + (N_SRC - 1) * 4);
   localparam logic [31:0] PEND_LO = 32'(PEND_BASE);
   localparam logic [31:0] PEND_HI = 32'(PEND_BASE + NWORDS * 4);
   localparam logic [31:0] ENA_LO  = 32'(ENA_BASE);
   localparam logic [31:0] ENA_HI  = 32'(ENA_BASE + N_CTX * ENA_STRIDE);
   localparam logic [31:0] CTX_LO  = 32'(CTX_BASE);
   localparam logic [31:0] CTX_HI  = 32'(CTX_BASE + N_CTX * CTX_STRIDE);
   localparam logic [31:0] ENA_M   = 32'(ENA_STRIDE - 1);
   localparam logic [31:0] CTX_M   = 32'(CTX_STRIDE - 1);

   // elaboration-time parameter checks
   if (N_SRC < 2)                        $error("irq_hub: N_SRC must be at least 2");
   if (N_HART < 1)                       $error("irq_hub: N_HART must be at least 1");
   if (NUM_PRIO > 7)                     $error("irq_hub: NUM_PRIO exceeds 3-bit priority");
   if (ADDR_W < 4 || ADDR_W > 32)        $error("irq_hub: ADDR_W out of range");
   if ((ENA_STRIDE & (ENA_STRIDE - 1)) != 0) $error("irq_hub: ENA_STRIDE not a power of two");
   if ((CTX_STRIDE & (CTX_STRIDE - 1)) != 0) $error("irq_hub: CTX_STRIDE not a power of two");
   if (ENA_STRIDE < NWORDS * 4)          $error("irq_hub: ENA_STRIDE too small");
   if (CTX_STRIDE < 8)                   $error("irq_hub: CTX_STRIDE too small");

   // ---------------- source state ----------------
   logic [N_SRC-1:0]  pending_w, claimed_w;
   prio_t [N_SRC-1:0] prio_w;

   // ---------------- decode ----------------
   region_e           region;
   logic [31:0]       a32, offs;
   logic [ID_W-1:0]   src_idx;
   logic [CTX_W-1:0]  ctx_sel;
   logic [WSEL_W-1:0] wsel;

   always_comb begin
      a32     = 32'(req_addr_i);
      offs    = '0;
      region  = RG_NONE;
      src_idx = '0;
      ctx_sel = '0;
      wsel    = '0;
      if (a32[1:0] == 2'b00) begin
         if (a32 >= PRIO_LO && a32 < PRIO_HI) begin
            offs    = a32 - PRIO_LO;
            region  = RG_PRIO;
            src_idx = ID_W'((offs >> 2) + 32'd1);
         end else if (a32 >= PEND_LO && a32 < PEND_HI) begin
            offs   = a32 - PEND_LO;
            region = RG_PEND;
            wsel   = WSEL_W'(offs >> 2);
         end else if (a32 >= ENA_LO && a32 < ENA_HI) begin
            offs    = a32 - ENA_LO;
            ctx_sel = CTX_W'(offs >> ENA_SH);
            wsel    = WSEL_W'((offs & ENA_M) >> 2);
            if (((offs & ENA_M) >> 2) < 32'(NWORDS)) region = RG_ENA;
         end else if (a32 >= CTX_LO && a32 < CTX_HI) begin
            offs    = a32 - CTX_LO;
            ctx_sel = CTX_W'(offs >> CTX_SH);
            if ((offs & CTX_M) == 32'd0)      region = RG_THR;
            else if ((offs & CTX_M) == 32'd4) region = RG_CLAIM;
         end
      end
   end

   logic wr, rd;
   assign wr = req_valid_i &&  req_write_i;
   assign rd = req_valid_i && !req_write_i;

   // ---------------- contexts ----------------
   logic [NWORDS-1:0][31:0] ena_all [N_CTX];
   prio_t [N_CTX-1:0]       thr_all;
   logic [ID_W-1:0]         best_all [N_CTX];
   logic [N_CTX-1:0]        ctx_irq;
   logic                    thr_ok;

   assign thr_ok = (req_wdata_i <= 32'(NUM_PRIO));

   for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
      logic sel;
      assign sel = (ctx_sel == CTX_W'(c));

      irq_hub_ctx #(
         .N_SRC     (N_SRC),
         .NWORDS    (NWORDS),
         .ID_W      (ID_W),
         .WSEL_W    (WSEL_W),
         .PICK_TREE (PICK_TREE)
      ) u_ctx (
         .clk      (clk),
         .rst_n    (rst_n),
         .ena_we   (wr && sel && (region == RG_ENA)),
         .ena_word (wsel),
         .wdata    (req_wdata_i),
         .thr_we   (wr && sel && (region == RG_THR) && thr_ok),
         .pending  (pending_w),
         .claimed  (claimed_w),
         .prio     (prio_w),
         .ena_q    (ena_all[c]),
         .thr_q    (thr_all[c]),
         .best_id  (best_all[c]),
         .irq      (ctx_irq[c])
      );
   end

   // ---------------- claim / complete ----------------
   logic            take_en, give_en, prio_we;
   logic [ID_W-1:0] take_id, give_id;

   assign take_id = best_all[ctx_sel];
   assign take_en = rd && (region == RG_CLAIM) && (take_id != '0);
   assign give_id = ID_W'(req_wdata_i);
   assign give_en = wr && (region == RG_CLAIM) && (req_wdata_i < 32'(N_SRC));
   assign prio_we = wr && (region == RG_PRIO);

   irq_hub_srcbank #(
      .N_SRC (N_SRC),
      .ID_W  (ID_W)
   ) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_i      (src_i),
      .prio_we    (prio_we),
      .prio_idx   (src_idx),
      .prio_wdata (req_wdata_i[PRIO_W-1:0]),
      .take_en    (take_en),
      .take_id    (take_id),
      .give_en    (give_en),
      .give_id    (give_id),
      .pending    (pending_w),
      .claimed    (claimed_w),
      .prio       (prio_w)
   );

   // ---------------- read response ----------------
   logic [NWORDS-1:0][31:0] pend_words;
   logic [31:0]             rd_d;

   assign pend_words = (NWORDS * 32)'(pending_w);

   always_comb begin
      unique case (region)
         RG_PRIO:  rd_d = 32'(prio_w[src_idx]);
         RG_PEND:  rd_d = pend_words[wsel];
         RG_ENA:   rd_d = ena_all[ctx_sel][wsel];
         RG_THR:   rd_d = 32'(thr_all[ctx_sel]);
         RG_CLAIM: rd_d = 32'(take_id);
         default:  rd_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid_o <= 1'b0;
         rsp_rdata_o <= '0;
      end else begin
         rsp_valid_o <= req_valid_i;
         rsp_rdata_o <= rd ? rd_d : '0;
      end
   end

   // ---------------- line mapping ----------------
   if (HAS_SUP) begin : g_ms
      for (genvar h = 0; h < N_HART; h++) begin : g_h
         assign m_eip_o[h] = ctx_irq[2*h];
         assign s_eip_o[h] = ctx_irq[2*h+1];
      end
   end else begin : g_m
      assign m_eip_o = ctx_irq[N_HART-1:0];
      assign s_eip_o = '0;
   end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
   import irq_hub_pkg::*;
#(
   parameter int unsigned N_HART   = 2,
   parameter int unsigned N_SRC    = 40,
   parameter int unsigned N_CTX    = 4,
   parameter int unsigned NUM_PRIO = 7,
   parameter int unsigned ID_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid_i,
   input logic              req_write_i,
   input logic [1:0]        addr_lo,
   input logic              rsp_valid_o,
   input logic [31:0]       rsp_rdata_o,
   input logic [N_HART-1:0] m_eip_o,
   input logic [N_HART-1:0] s_eip_o,
   input logic [N_SRC-1:0]  pending,
   input logic [N_SRC-1:0]  claimed,
   input prio_t [N_CTX-1:0] thr_all,
   input logic              take_en,
   input logic [ID_W-1:0]   take_id,
   input logic              give_en,
   input logic [ID_W-1:0]   give_id
);

   p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid_i |=> rsp_valid_o);

   p_rsp_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid_i |=> !rsp_valid_o);

   p_bad_align_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid_i && !req_write_i && (addr_lo != 2'b00)) |=> (rsp_rdata_o == 32'd0));

   for (genvar c = 0; c < N_CTX; c++) begin : g_thr
      p_thr_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
         32'(thr_all[c]) <= 32'(NUM_PRIO));
   end

   p_line_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((m_eip_o != '0) || (s_eip_o != '0)) |-> ((pending & ~claimed) != '0));

   p_claim_move_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |=> (claimed[$past(take_id)] && !pending[$past(take_id)]));

   p_claim_echo_r7: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |=> (rsp_rdata_o == 32'($past(take_id))));

   p_complete_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      give_en |=> !claimed[$past(give_id)]);

endmodule

bind irq_hub irq_hub_chk #(
   .N_HART   (N_HART),
   .N_SRC    (N_SRC),
   .N_CTX    (N_CTX),
   .NUM_PRIO (NUM_PRIO),
   .ID_W     (ID_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid_i (req_valid_i),
   .req_write_i (req_write_i),
   .addr_lo     (req_addr_i[1:0]),
   .rsp_valid_o (rsp_valid_o),
   .rsp_rdata_o (rsp_rdata_o),
   .m_eip_o     (m_eip_o),
   .s_eip_o     (s_eip_o),
   .pending     (pending_w),
   .claimed     (claimed_w),
   .thr_all     (thr_all),
   .take_en     (take_en),
   .take_id     (take_id),
   .give_en     (give_en),
   .give_id     (give_id)
);

// File: tb/irq_hub_tb.sv
`timescale 1ns/1ps
module irq_hub_tb;

   localparam int N_HART = 2;
   localparam int N_SRC  = 40;
   localparam int ADDR_W = 16;
   localparam int WD_CYC = 50000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid_i = 1'b0;
   logic              req_write_i = 1'b0;
   logic [ADDR_W-1:0] req_addr_i = '0;
   logic [31:0]       req_wdata_i = '0;
   logic              rsp_valid_o;
   logic [31:0]       rsp_rdata_o;
   logic [N_SRC-1:0]  src_i = '0;
   logic [N_HART-1:0] m_eip_o, s_eip_o;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   irq_hub u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_addr_i  (req_addr_i),
      .req_wdata_i (req_wdata_i),
      .rsp_valid_o (rsp_valid_o),
      .rsp_rdata_o (rsp_rdata_o),
      .src_i       (src_i),
      .m_eip_o     (m_eip_o),
      .s_eip_o     (s_eip_o)
   );

   function automatic logic [15:0] a_prio(int s);      return 16'((s - 1) * 4); endfunction
   function automatic logic [15:0] a_pend(int w);      return 16'(32'h1000 + 4 * w); endfunction
   function automatic logic [15:0] a_ena(int c, int w); return 16'(32'h2000 + c * 32'h80 + 4 * w); endfunction
   function automatic logic [15:0] a_thr(int c);       return 16'(32'h4000 + c * 32'h100); endfunction
   function automatic logic [15:0] a_clm(int c);       return 16'(32'h4004 + c * 32'h100); endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(logic [15:0] addr, logic [31:0] data);
      @(negedge clk);
      req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = addr; req_wdata_i = data;
      @(negedge clk);
      req_valid_i = 1'b0; req_write_i = 1'b0;
   endtask

   task automatic bus_rd(logic [15:0] addr, output logic [31:0] data, output logic vld);
      @(negedge clk);
      req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = addr;
      @(negedge clk);
      data = rsp_rdata_o; vld = rsp_valid_o;
      req_valid_i = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [15:0] addr, logic [31:0] exp);
      logic [31:0] d; logic v;
      bus_rd(addr, d, v);
      chk({req, " rsp_valid"}, 32'(v), 32'd1);
      chk(req, d, exp);
   endtask

   task automatic src_set(int s, logic lvl);
      @(negedge clk);
      src_i[s] = lvl;
      @(negedge clk);
   endtask

   task automatic lines_chk(string req, logic [1:0] m_exp, logic [1:0] s_exp);
      chk({req, " m_eip"}, 32'(m_eip_o), 32'(m_exp));
      chk({req, " s_eip"}, 32'(s_eip_o), 32'(s_exp));
   endtask

   task automatic t_reset();
      lines_chk("R10 reset lines", 2'b00, 2'b00);
      rd_chk("R10 reset prio", a_prio(1), 32'd0);
      rd_chk("R10 reset pending", a_pend(0), 32'd0);
      rd_chk("R10 reset enable", a_ena(2, 1), 32'd0);
      rd_chk("R10 reset threshold", a_thr(3), 32'd0);
   endtask

   task automatic t_prio();
      bus_wr(a_prio(1), 32'hFF);
      rd_chk("R2 prio low bits", a_prio(1), 32'd7);
      bus_wr(a_prio(5), 32'h12);
      rd_chk("R2 prio source k+1", a_prio(5), 32'd2);
      rd_chk("R2 prio neighbour", a_prio(4), 32'd0);
   endtask

   task automatic t_bus();
      logic [31:0] d; logic v;
      bus_rd(16'h0002, d, v);
      chk("R1 misaligned read valid", 32'(v), 32'd1);
      chk("R1 misaligned read zero", d, 32'd0);
      rd_chk("R1 unmapped read zero", 16'h3000, 32'd0);
      bus_wr(16'h0006, 32'h5);
      rd_chk("R1 misaligned write dropped", a_prio(2), 32'd0);
      bus_wr(16'h4008, 32'h3);
      rd_chk("R1 unmapped ctx offset", 16'h4008, 32'd0);
   endtask

   task automatic t_pending();
      src_set(3, 1'b1);
      src_set(35, 1'b1);
      rd_chk("R3 pending word0", a_pend(0), 32'h0000_0008);
      rd_chk("R3 pending word1", a_pend(1), 32'h0000_0008);
      bus_wr(a_pend(0), 32'h0);
      rd_chk("R3 pending write ignored", a_pend(0), 32'h0000_0008);
      src_set(35, 1'b0);
      rd_chk("R3 pending falls", a_pend(1), 32'h0);
      src_set(3, 1'b0);
      rd_chk("R3 pending falls word0", a_pend(0), 32'h0);
   endtask

   task automatic t_enable();
      bus_wr(a_ena(1, 0), 32'hA5A5_0000);
      rd_chk("R4 enable readback", a_ena(1, 0), 32'hA5A5_0000);
      rd_chk("R4 other context untouched", a_ena(0, 0), 32'h0);
      bus_wr(a_ena(1, 2), 32'hFFFF);
      rd_chk("R4 word beyond range", a_ena(1, 2), 32'h0);
      rd_chk("R4 word beyond range no alias", a_ena(1, 0), 32'hA5A5_0000);
      bus_wr(a_ena(1, 0), 32'h0);
      rd_chk("R4 enable cleared", a_ena(1, 0), 32'h0);
   endtask

   task automatic t_threshold();
      bus_wr(a_thr(0), 32'd5);
      rd_chk("R5 threshold write", a_thr(0), 32'd5);
      bus_wr(a_thr(0), 32'd8);
      rd_chk("R5 threshold above limit ignored", a_thr(0), 32'd5);
      bus_wr(a_thr(0), 32'd7);
      rd_chk("R5 threshold at limit", a_thr(0), 32'd7);
      bus_wr(a_thr(0), 32'd0);
   endtask

   task automatic t_claim();
      bus_wr(a_prio(6), 32'd2);
      bus_wr(a_prio(33), 32'd4);
      bus_wr(a_ena(0, 0), 32'h60);
      bus_wr(a_ena(0, 1), 32'h2);
      lines_chk("R6 enabled but idle", 2'b00, 2'b00);
      @(negedge clk);
      src_i[5] = 1'b1; src_i[6] = 1'b1; src_i[33] = 1'b1;
      @(negedge clk);
      lines_chk("R9 machine context line", 2'b01, 2'b00);
      rd_chk("R7 claim highest priority", a_clm(0), 32'd33);
      rd_chk("R7 claim clears pending", a_pend(1), 32'h0);
      rd_chk("R7 claim tie lowest id", a_clm(0), 32'd5);
      rd_chk("R7 claim next", a_clm(0), 32'd6);
      lines_chk("R6 all claimed", 2'b00, 2'b00);
      rd_chk("R7 claim none", a_clm(0), 32'd0);
      rd_chk("R7 held input no repend", a_pend(0), 32'h0);
      bus_wr(a_clm(0), 32'd40);
      src_set(5, 1'b0);
      src_set(5, 1'b1);
      rd_chk("R3 repend after toggle", a_pend(0), 32'h20);
      lines_chk("R8 large complete ignored", 2'b00, 2'b00);
      bus_wr(a_clm(0), 32'd5);
      lines_chk("R8 complete releases", 2'b01, 2'b00);
      bus_wr(a_thr(0), 32'd2);
      lines_chk("R6 priority equal threshold", 2'b00, 2'b00);
      bus_wr(a_thr(0), 32'd1);
      lines_chk("R6 priority above threshold", 2'b01, 2'b00);
      bus_wr(a_thr(0), 32'd0);
   endtask

   task automatic t_sup();
      bus_wr(a_ena(1, 0), 32'h20);
      lines_chk("R9 supervisor hart0", 2'b01, 2'b01);
      bus_wr(a_ena(3, 0), 32'h20);
      lines_chk("R9 supervisor hart1", 2'b01, 2'b11);
      rd_chk("R7 claim from other context", a_clm(3), 32'd5);
      lines_chk("R7 claim hides source everywhere", 2'b00, 2'b00);
      bus_wr(a_clm(1), 32'd5);
      bus_wr(a_clm(0), 32'd6);
      bus_wr(a_clm(0), 32'd33);
      rd_chk("R8 completed source not pending", a_clm(2), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_prio();
      t_bus();
      t_pending();
      t_enable();
      t_threshold();
      t_claim();
      t_sup();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(WD_CYC * 10);
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule